// File: doc/BRIEF.md
# External Pin Interrupt Request Logic

This block converts a single external input pin into an interrupt request for a small microcontroller core. A three-bit pin control register does two jobs. It gates the pin input. It also chooses what counts as a valid event: a falling or rising transition, or a low or high level. Valid events latch into a request flag.

A one-bit interrupt enable decides how the core sees the flag:

- **Enable set:** the flag is forwarded to the interrupt system. A one-cycle acknowledge from the core clears it.
- **Enable clear:** the core polls the flag with a test-and-clear operation. That operation reports, one cycle later, whether the next instruction should be skipped.

The detector compares the gated, polarity-adjusted input with its value from the previous cycle. This means rewriting the enable or polarity bits can create an apparent edge and set the flag on its own. Software is expected to disable the interrupt, reprogram, and then poll the flag clear.

A separate wake enable drives an unclocked wake request. The request follows the raw pin level, so it can bring the device out of a retention low-power hold.

Top module: `pinirq_top`

## Requirements
- R1: After synchronous reset, the input is disabled, falling-edge mode is selected, the interrupt enable and wake enable are 0, and the flag is clear, so `irq_o`, `skip_o` and `wake_o` are 0.
- R2: The control write data `ctl_wd` has this layout: bit 2 enables the pin input, bit 1 selects polarity (0 = falling edge or low level, 1 = rising edge or high level), and bit 0 selects level mode (1) or edge mode (0). With bit 2 at 0, no pin activity sets the flag.
- R3: In edge mode, the flag is set only by a transition of the pin into the selected active level. A transition the other way has no effect.
- R4: In level mode, the flag is set on every cycle in which the synchronized pin is at the selected active level.
- R5: Writing the control register so that the gated, polarity-adjusted signal goes from 0 to 1 sets the flag in edge mode. This happens both when enabling the input and when changing polarity, even if the pin does not move.
- R6: `irq_o` is 1 exactly when the flag is set and the interrupt enable is 1.
- R7: A `test_i` pulse while the interrupt enable is 0 gives, in the following cycle, `skip_o` equal to the flag value it found, and clears the flag. With the interrupt enable at 1, `test_i` is ignored: `skip_o` stays 0 and the flag is kept.
- R8: An `ack_i` pulse clears the flag.
- R9: If an event and a clear from `ack_i` or `test_i` occur in the same cycle, the flag ends up set.
- R10: `wake_o` is 1 when the wake enable is 1, the input is enabled, and the raw pin is at the selected active level. It is combinational and needs no clock edge.
- R11: A pin edge that is a valid event becomes visible on `irq_o` after the third rising clock edge following the pin change. Two of those edges are synchronizer stages and one is the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| ctl_we | input | 1 | Write strobe for the pin control register |
| ctl_wd | input | 3 | Control data: [2] input enable, [1] polarity, [0] level mode |
| ien_we | input | 1 | Write strobe for the interrupt enable |
| ien_wd | input | 1 | Interrupt enable value |
| wke_we | input | 1 | Write strobe for the wake enable |
| wke_wd | input | 1 | Wake enable value |
| test_i | input | 1 | Test-and-clear request from the core |
| ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| irq_o | output | 1 | Interrupt request to the core |
| skip_o | output | 1 | Skip indication, one cycle after `test_i` |
| wake_o | output | 1 | Wake request, combinational from the pin |

## Verification
The main sweep tries every combination of input enable, polarity, edge or level mode, and pin start and end level. This separates a true edge detector from a level detector, and a correct polarity from an inverted one. It also shows that a disabled input sets nothing and that a reverse transition is ignored.

Directed patterns cover the rest:
- Writing the control register with the pin held still tells apart a detector that sees configuration-created edges from one that only watches the pin.
- Edge-cycle sampling pins down the three-edge latency.
- A held active level in level mode, combined with acknowledge and test pulses, tells a set-wins flag from a clear-wins one.
- Tests with the enable at 1 show that polling is ignored in that state.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int CFG_W       = 3;
  localparam int CFG_EN_BIT  = 2;
  localparam int CFG_POL_BIT = 1;
  localparam int CFG_LVL_BIT = 0;

  typedef struct packed {
    logic en;
    logic pol;
    logic lvl;
  } pin_cfg_t;

  function automatic pin_cfg_t unpack_cfg(input logic [CFG_W-1:0] d);
    pin_cfg_t c;
    c.en  = d[CFG_EN_BIT];
    c.pol = d[CFG_POL_BIT];
    c.lvl = d[CFG_LVL_BIT];
    return c;
  endfunction
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     s_i,
  input  pin_cfg_t cfg_i,
  output logic     event_o
);
  logic adj;
  logic gated;
  logic prev_q;

  // Polarity-adjust, then gate: config changes alone can raise gated.
  assign adj   = cfg_i.pol ? s_i : ~s_i;
  assign gated = cfg_i.en & adj;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= gated;
  end

  assign event_o = cfg_i.lvl ? gated : (gated & ~prev_q);

  // R3: an edge event means the stored history is high on the next cycle
  p_edge_history_r3: assert property (@(posedge clk) disable iff (rst)
    (event_o && !cfg_i.lvl) |=> prev_q);
endmodule

// File: rtl/pinirq_flag.sv
module pinirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic test_i,
  input  logic ack_i,
  input  logic ien_i,
  output logic flag_o,
  output logic irq_o,
  output logic skip_o
);
  logic flag_q;
  logic skip_q;
  logic test_ok;
  logic clr;
  logic flag_d;

  assign test_ok = test_i & ~ien_i;
  assign clr     = ack_i | test_ok;
  assign flag_d  = event_i | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      skip_q <= test_ok & flag_q;
    end
  end

  assign flag_o = flag_q;
  assign skip_o = skip_q;
  assign irq_o  = flag_q & ien_i;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    event_i |=> flag_q);
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !event_i) |=> !flag_q);
  p_skip_source_r7: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> ($past(test_i) && !$past(ien_i) && $past(flag_q)));
  p_test_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (test_i && ien_i && !ack_i && flag_q) |=> flag_q);
endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             ctl_we,
  input  logic [CFG_W-1:0] ctl_wd,
  input  logic             ien_we,
  input  logic             ien_wd,
  input  logic             wke_we,
  input  logic             wke_wd,
  input  logic             test_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             skip_o,
  output logic             wake_o
);
  pin_cfg_t cfg_q;
  logic     ien_q;
  logic     wke_q;
  logic     pin_s;
  logic     evt;
  logic     flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{en: 1'b0, pol: 1'b0, lvl: 1'b0};
      ien_q <= 1'b0;
      wke_q <= 1'b0;
    end else begin
      if (ctl_we) cfg_q <= unpack_cfg(ctl_wd);
      if (ien_we) ien_q <= ien_wd;
      if (wke_we) wke_q <= wke_wd;
    end
  end

  pinirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  pinirq_detect u_det (
    .clk     (clk),
    .rst     (rst),
    .s_i     (pin_s),
    .cfg_i   (cfg_q),
    .event_o (evt)
  );

  pinirq_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .event_i (evt),
    .test_i  (test_i),
    .ack_i   (ack_i),
    .ien_i   (ien_q),
    .flag_o  (flag),
    .irq_o   (irq_o),
    .skip_o  (skip_o)
  );

  // Unclocked path from the raw pin, usable while the clock is stopped.
  assign wake_o = wke_q & cfg_q.en & (cfg_q.pol ? pin_i : ~pin_i);

  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(cfg_q.en));
  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ien_q && flag));
  p_wake_enable_r10: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (wke_q && cfg_q.en));
endmodule

// File: tb/sim_pinirq_top.sv
module sim_pinirq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_i = 1'b1;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_wd = 3'b000;
  logic       ien_we = 1'b0, ien_wd = 1'b0;
  logic       wke_we = 1'b0, wke_wd = 1'b0;
  logic       test_i = 1'b0, ack_i = 1'b0;
  logic       irq_o, skip_o, wake_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pinirq_top u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .ctl_we(ctl_we), .ctl_wd(ctl_wd),
    .ien_we(ien_we), .ien_wd(ien_wd),
    .wke_we(wke_we), .wke_wd(wke_wd),
    .test_i(test_i), .ack_i(ack_i),
    .irq_o(irq_o), .skip_o(skip_o), .wake_o(wake_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_ctl(input logic en, input logic pol, input logic lvl);
    ctl_wd = {en, pol, lvl};
    ctl_we = 1'b1;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic write_ien(input logic v);
    ien_wd = v; ien_we = 1'b1; tick(); ien_we = 1'b0;
  endtask

  task automatic write_wke(input logic v);
    wke_wd = v; wke_we = 1'b1; tick(); wke_we = 1'b0;
  endtask

  // Test-and-clear; returns skip seen the cycle after the pulse.
  task automatic poll(output logic s);
    test_i = 1'b1;
    tick();
    test_i = 1'b0;
    s = skip_o;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic s;
    logic exp;
    logic act_s, act_e;

    tick(3);
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 irq", irq_o, 1'b0);
    check("R1 skip", skip_o, 1'b0);
    check("R1 wake", wake_o, 1'b0);
    pin_i = 1'b0;
    tick(4);
    poll(s);
    check("R1/R2 disabled-input flag", s, 1'b0);

    write_wke(1'b1);

    // Sweep: enable x level mode x polarity x start x end (R2,R3,R4,R10)
    for (int en = 0; en < 2; en++)
      for (int lv = 0; lv < 2; lv++)
        for (int po = 0; po < 2; po++)
          for (int st = 0; st < 2; st++)
            for (int ed = 0; ed < 2; ed++) begin
              pin_i = st[0];
              tick(4);
              write_ctl(en[0], po[0], lv[0]);
              tick(4);
              poll(s);
              pin_i = ed[0];
              #1;
              act_e = po[0] ? ed[0] : ~ed[0];
              act_s = po[0] ? st[0] : ~st[0];
              check("R10 wake level", wake_o, en[0] & act_e);
              tick(5);
              poll(s);
              if (lv[0]) exp = en[0] & (act_s | act_e);
              else       exp = en[0] & ~act_s & act_e;
              if (!en[0])     check("R2 gated sweep", s, exp);
              else if (lv[0]) check("R4 level sweep", s, exp);
              else            check("R3 edge sweep", s, exp);
            end

    // R5: enabling with pin at active level creates an edge
    pin_i = 1'b0;
    write_ctl(1'b0, 1'b0, 1'b0);
    tick(4);
    poll(s);
    write_ctl(1'b1, 1'b0, 1'b0);
    tick(2);
    poll(s);
    check("R5 enable edge", s, 1'b1);
    // R5: polarity change with pin still
    write_ctl(1'b1, 1'b1, 1'b0);
    tick(3);
    poll(s);
    check("R5 polarity quiet", s, 1'b0);
    write_ctl(1'b1, 1'b0, 1'b0);
    tick(2);
    poll(s);
    check("R5 polarity edge", s, 1'b1);

    // R6/R11: forwarded interrupt and latency (falling edge mode)
    pin_i = 1'b1;
    tick(4);
    poll(s);
    write_ien(1'b1);
    check("R6 no flag no irq", irq_o, 1'b0);
    pin_i = 1'b0;
    tick(2);
    check("R11 irq not before third edge", irq_o, 1'b0);
    tick();
    check("R11 irq at third edge", irq_o, 1'b1);
    // R7: test ignored while enabled
    poll(s);
    check("R7 skip ignored when enabled", s, 1'b0);
    check("R7 flag kept when enabled", irq_o, 1'b1);
    // R6: disabling hides irq, flag still pollable
    write_ien(1'b0);
    check("R6 irq masked", irq_o, 1'b0);
    write_ien(1'b1);
    check("R6 irq back", irq_o, 1'b1);
    // R8: ack clears
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R8 ack clears", irq_o, 1'b0);
    write_ien(1'b0);
    poll(s);
    check("R8 flag empty after ack", s, 1'b0);

    // R9: held active level, clears lose to set
    write_ctl(1'b1, 1'b0, 1'b1);
    tick(2);
    poll(s);
    check("R9 test vs set skip", s, 1'b1);
    poll(s);
    check("R9 flag survives test", s, 1'b1);
    write_ien(1'b1);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R9 flag survives ack", irq_o, 1'b1);

    // R10: wake disabled
    write_wke(1'b0);
    #1;
    check("R10 wake off", wake_o, 1'b0);
    write_wke(1'b1);
    pin_i = 1'b1;
    #1;
    check("R10 wake inactive level", wake_o, 1'b0);
    pin_i = 1'b0;
    #1;
    check("R10 wake unclocked", wake_o, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule